// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit sits between instruction decode and execution. It takes the addressing-mode code, the instruction's address field and the current register values, and produces one of three results. The first is a memory effective address. The second is an operand that is already in hand: the immediate field or a register value. The third is neither, for implied operands. For the auto-increment and auto-decrement modes it also produces the adjusted register value to be written back.

Every mode except memory-indirect returns its result one cycle after the request is accepted. Memory-indirect first reads memory at the address field through a read port. That takes one extra cycle, during which `busy` is high and new requests are ignored. The word that comes back is used as the effective address.

Top module: `ea_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `res_valid`, `res_is_addr`, `res_is_opnd`, `wb_en`, `busy` and `mem_rd_en` all go to 0.
- R2: Mode 0 (implied) gives `res_valid`=1 with `res_is_addr`=0 and `res_is_opnd`=0 in the cycle after acceptance. Reserved codes 11 to 15 behave the same way.
- R3: Mode 1 (immediate) gives `res_is_opnd`=1 with `res_opnd` equal to the address field zero-extended to AW bits.
- R4: Mode 2 (register) gives `res_is_opnd`=1 with `res_opnd`=`reg_val`. Mode 3 (register indirect) gives `res_is_addr`=1 with `res_ea`=`reg_val`.
- R5: Mode 4 (autoincrement) and mode 5 (autodecrement) give `res_ea` equal to the unmodified `reg_val`. They also assert `wb_en` with `wb_val` = `reg_val`+1 (mode 4) or `reg_val`-1 (mode 5), wrapping modulo 2^AW.
- R6: Mode 6 (direct) gives `res_is_addr`=1 with `res_ea` equal to the zero-extended address field.
- R7: For mode 7 (indirect), in the cycle after acceptance: `busy`=1, `mem_rd_en`=1, `mem_rd_addr` = the zero-extended field, and `res_valid`=0. In the next cycle: `res_valid`=1, `res_is_addr`=1, and `res_ea` = the `mem_rd_data` present during the read cycle.
- R8: A request presented while `busy` is high is ignored. It produces no result and no further read.
- R9: Mode 8 (PC-relative) gives `res_ea` = `pc` + the sign-extended field, modulo 2^AW.
- R10: Mode 9 (indexed) gives `res_ea` = `idx_reg` + the zero-extended field. Mode 10 (base) gives `res_ea` = `base_reg` + the zero-extended field. Both wrap modulo 2^AW.
- R11: Every mode other than 7 asserts `res_valid` for exactly one cycle, in the cycle right after acceptance. `wb_en` is high only for modes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing-mode code |
| req_field | input | FW | Instruction address/operand field |
| reg_val | input | AW | Value of the register named by the instruction |
| pc | input | AW | Program counter |
| idx_reg | input | AW | Index register |
| base_reg | input | AW | Base register |
| mem_rd_data | input | AW | Read data, valid while mem_rd_en is high |
| mem_rd_en | output | 1 | Indirect pointer read in progress |
| mem_rd_addr | output | AW | Address of the pointer read |
| busy | output | 1 | Indirect fetch in progress; requests ignored |
| res_valid | output | 1 | Result outputs valid this cycle |
| res_is_addr | output | 1 | res_ea holds a memory effective address |
| res_ea | output | AW | Effective address |
| res_is_opnd | output | 1 | res_opnd holds the operand itself |
| res_opnd | output | AW | Immediate or register operand |
| wb_en | output | 1 | Write wb_val back to the selected register |
| wb_val | output | AW | Adjusted register value for auto modes |

## Verification
The hardest case to reach is a request that arrives during the one-cycle indirect fetch window. The bench starts an indirect request and then holds a direct-mode request on the inputs for exactly the fetch cycle. It checks that the indirect result appears next, and that the cycle after it shows no result and no second read. The arithmetic wrap cases are also driven on purpose: a negative displacement taken across zero, a positive one taken across the top of the address space, an increment of all-ones and a decrement of zero.

// File: rtl/ea_pkg.sv
// Package: shared addressing-mode codes for the effective address unit.
// Assumes a 4-bit mode field; codes above MODE_BASE are reserved.
package ea_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_IMPLIED  = 4'd0,
        MODE_IMM      = 4'd1,
        MODE_REG      = 4'd2,
        MODE_REG_IND  = 4'd3,
        MODE_AUTO_INC = 4'd4,
        MODE_AUTO_DEC = 4'd5,
        MODE_DIRECT   = 4'd6,
        MODE_INDIRECT = 4'd7,
        MODE_PC_REL   = 4'd8,
        MODE_INDEXED  = 4'd9,
        MODE_BASE     = 4'd10
    } ea_mode_e;
endpackage

// File: rtl/ea_field_ext.sv
// Module: widens the instruction field to address width, both zero- and
// sign-extended. Assumes FW <= AW.
module ea_field_ext #(
    parameter int FW = 8,
    parameter int AW = 16
) (
    input  logic [FW-1:0] field,
    output logic [AW-1:0] zext,
    output logic [AW-1:0] sext
);
    localparam int PAD = AW - FW;

    // Pick the widening form according to whether padding is needed
    generate
        if (PAD > 0) begin : g_pad
            assign zext = {{PAD{1'b0}}, field};
            assign sext = {{PAD{field[FW-1]}}, field};
        end else begin : g_same
            assign zext = field;
            assign sext = field;
        end
    endgenerate
endmodule

// File: rtl/ea_addr_calc.sv
// Module: combinational per-mode result select. Produces the address or
// operand, the result kind flags and the auto-mode write-back value.
// Assumes inputs are stable for the cycle the request is presented.
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     fld_z,
    input  logic [AW-1:0]     fld_s,
    input  logic [AW-1:0]     reg_val,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     idx_reg,
    input  logic [AW-1:0]     base_reg,
    output logic              is_addr,
    output logic [AW-1:0]     ea,
    output logic              is_opnd,
    output logic [AW-1:0]     opnd,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val,
    output logic              is_indirect
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Decode the mode into a result kind and compute its value
    always_comb begin
        is_addr     = 1'b0;
        ea          = '0;
        is_opnd     = 1'b0;
        opnd        = '0;
        wb_en       = 1'b0;
        wb_val      = '0;
        is_indirect = 1'b0;
        case (mode)
            MODE_IMM:      begin is_opnd = 1'b1; opnd = fld_z;   end
            MODE_REG:      begin is_opnd = 1'b1; opnd = reg_val; end
            MODE_REG_IND:  begin is_addr = 1'b1; ea = reg_val;   end
            MODE_AUTO_INC: begin
                is_addr = 1'b1; ea = reg_val;
                wb_en   = 1'b1; wb_val = reg_val + ONE;
            end
            MODE_AUTO_DEC: begin
                is_addr = 1'b1; ea = reg_val;
                wb_en   = 1'b1; wb_val = reg_val - ONE;
            end
            MODE_DIRECT:   begin is_addr = 1'b1; ea = fld_z; end
            MODE_INDIRECT: begin is_indirect = 1'b1; end
            MODE_PC_REL:   begin is_addr = 1'b1; ea = pc + fld_s; end
            MODE_INDEXED:  begin is_addr = 1'b1; ea = idx_reg + fld_z; end
            MODE_BASE:     begin is_addr = 1'b1; ea = base_reg + fld_z; end
            default:       begin end
        endcase
    end

    // Result kinds are exclusive: an address, an operand, or neither (R2)
    always_comb begin
        assert (!(is_addr && is_opnd)) else $error("p_kind_exclusive_r2");
    end
endmodule

// File: rtl/ea_indirect_ctl.sv
// Module: one-cycle pointer fetch for memory-indirect mode. Raises busy
// and the read strobe for the cycle after start; memory is assumed to
// return data in that same cycle.
module ea_indirect_ctl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ptr,
    output logic          busy,
    output logic [AW-1:0] rd_addr
);
    // Hold busy for exactly one cycle and latch the pointer address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd_addr <= '0;
        end else if (busy) begin
            busy    <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            rd_addr <= ptr;
        end
    end

    // The fetch lasts one cycle; no back-to-back fetch (R7, R8)
    p_fetch_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // A start from idle leads to a read at the offered pointer (R7)
    p_fetch_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rd_addr == $past(ptr)));
endmodule

// File: rtl/ea_unit.sv
// Module: effective address unit top. Accepts a request when not busy
// and registers the result one cycle later. Memory-indirect mode passes
// through the fetch controller and finishes one cycle after that.
// Assumes mem_rd_data is valid while mem_rd_en is high.
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [FW-1:0]     req_field,
    input  logic [AW-1:0]     reg_val,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     idx_reg,
    input  logic [AW-1:0]     base_reg,
    input  logic [AW-1:0]     mem_rd_data,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    output logic              busy,
    output logic              res_valid,
    output logic              res_is_addr,
    output logic [AW-1:0]     res_ea,
    output logic              res_is_opnd,
    output logic [AW-1:0]     res_opnd,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val
);
    logic [AW-1:0] fld_z, fld_s;
    logic          c_is_addr, c_is_opnd, c_wb_en, c_indirect;
    logic [AW-1:0] c_ea, c_opnd, c_wb_val;
    logic          accept, ind_start, fetching;

    ea_field_ext #(.FW(FW), .AW(AW)) u_ext (
        .field(req_field), .zext(fld_z), .sext(fld_s)
    );

    ea_addr_calc #(.AW(AW)) u_calc (
        .mode(req_mode), .fld_z(fld_z), .fld_s(fld_s), .reg_val(reg_val),
        .pc(pc), .idx_reg(idx_reg), .base_reg(base_reg),
        .is_addr(c_is_addr), .ea(c_ea), .is_opnd(c_is_opnd), .opnd(c_opnd),
        .wb_en(c_wb_en), .wb_val(c_wb_val), .is_indirect(c_indirect)
    );

    assign accept    = req_valid && !fetching;
    assign ind_start = accept && c_indirect;

    ea_indirect_ctl #(.AW(AW)) u_ind (
        .clk(clk), .rst_n(rst_n), .start(ind_start), .ptr(fld_z),
        .busy(fetching), .rd_addr(mem_rd_addr)
    );

    assign busy      = fetching;
    assign mem_rd_en = fetching;

    // Register the result: fetched pointer, direct mode result, or idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_is_addr <= 1'b0;
            res_ea      <= '0;
            res_is_opnd <= 1'b0;
            res_opnd    <= '0;
            wb_en       <= 1'b0;
            wb_val      <= '0;
        end else if (fetching) begin
            res_valid   <= 1'b1;
            res_is_addr <= 1'b1;
            res_ea      <= mem_rd_data;
            res_is_opnd <= 1'b0;
            res_opnd    <= '0;
            wb_en       <= 1'b0;
            wb_val      <= '0;
        end else if (accept && !c_indirect) begin
            res_valid   <= 1'b1;
            res_is_addr <= c_is_addr;
            res_ea      <= c_ea;
            res_is_opnd <= c_is_opnd;
            res_opnd    <= c_opnd;
            wb_en       <= c_wb_en;
            wb_val      <= c_wb_val;
        end else begin
            res_valid   <= 1'b0;
            res_is_addr <= 1'b0;
            res_is_opnd <= 1'b0;
            wb_en       <= 1'b0;
        end
    end

    // Non-indirect requests finish in the next cycle (R11)
    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode != MODE_INDIRECT) |=> res_valid);
    // No result is shown while the pointer read is in progress (R7)
    p_no_result_in_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !res_valid);
    // A completed fetch always yields an address result (R7)
    p_fetch_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (res_valid && res_is_addr));
    // Write-back only accompanies a valid address result (R5)
    p_wb_with_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (res_valid && res_is_addr));
    // Autoincrement writes back the pre-use value plus one (R5)
    p_autoinc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode == MODE_AUTO_INC)
        |=> (wb_en && res_ea == $past(reg_val) && wb_val == AW'($past(reg_val) + AW'(1))));
    // Result flags never claim both an address and an operand (R2)
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_is_addr && res_is_opnd));
endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
    localparam int AW = 16;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_mode = '0;
    logic [FW-1:0] req_field = '0;
    logic [AW-1:0] reg_val = '0;
    logic [AW-1:0] pc = 16'h0100;
    logic [AW-1:0] idx_reg = 16'h1000;
    logic [AW-1:0] base_reg = 16'h8000;
    logic [AW-1:0] mem_rd_data;
    logic          mem_rd_en, busy, res_valid, res_is_addr, res_is_opnd, wb_en;
    logic [AW-1:0] mem_rd_addr, res_ea, res_opnd, wb_val;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    // Memory model: pointer word derived from the address
    assign mem_rd_data = mem_rd_en ? (mem_rd_addr ^ 16'hA5C3) : 16'hDEAD;

    ea_unit #(.AW(AW), .FW(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_field(req_field), .reg_val(reg_val), .pc(pc), .idx_reg(idx_reg),
        .base_reg(base_reg), .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .busy(busy), .res_valid(res_valid),
        .res_is_addr(res_is_addr), .res_ea(res_ea), .res_is_opnd(res_is_opnd),
        .res_opnd(res_opnd), .wb_en(wb_en), .wb_val(wb_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request for one cycle; return just after the accepting edge
    task automatic issue(input logic [3:0] m, input logic [FW-1:0] f, input logic [AW-1:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_field = f; reg_val = r;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 res_valid", res_valid, 0);
        chk("R1 busy", busy, 0);
        chk("R1 mem_rd_en", mem_rd_en, 0);
        chk("R1 wb_en", wb_en, 0);
        chk("R1 kind", {res_is_addr, res_is_opnd}, 0);
    endtask

    task automatic t_implied;
        issue(4'd0, 8'h55, 16'h1234);
        chk("R2 implied valid", res_valid, 1);
        chk("R2 implied kind", {res_is_addr, res_is_opnd, wb_en}, 0);
        issue(4'd13, 8'h55, 16'h1234);
        chk("R2 reserved code", {res_valid, res_is_addr, res_is_opnd}, 3'b100);
        @(negedge clk);
        chk("R11 single-cycle valid", res_valid, 0);
    endtask

    task automatic t_imm_reg;
        issue(4'd1, 8'hC7, 16'h1234);
        chk("R3 imm kind", {res_is_opnd, res_is_addr}, 2'b10);
        chk("R3 imm value", res_opnd, 16'h00C7);
        issue(4'd2, 8'h00, 16'hBEEF);
        chk("R4 register operand", {res_is_opnd, res_opnd}, {1'b1, 16'hBEEF});
        issue(4'd3, 8'h00, 16'h4321);
        chk("R4 reg-indirect ea", {res_is_addr, res_ea}, {1'b1, 16'h4321});
        chk("R11 no wb in reg-ind", wb_en, 0);
    endtask

    task automatic t_auto;
        issue(4'd4, 8'h00, 16'h2000);
        chk("R5 inc ea pre-use", res_ea, 16'h2000);
        chk("R5 inc wb", {wb_en, wb_val}, {1'b1, 16'h2001});
        issue(4'd4, 8'h00, 16'hFFFF);
        chk("R5 inc wrap", wb_val, 16'h0000);
        issue(4'd5, 8'h00, 16'h0000);
        chk("R5 dec ea pre-use", res_ea, 16'h0000);
        chk("R5 dec wrap", {wb_en, wb_val}, {1'b1, 16'hFFFF});
    endtask

    task automatic t_direct_rel_idx;
        issue(4'd6, 8'hF3, 16'h9999);
        chk("R6 direct", {res_is_addr, res_ea}, {1'b1, 16'h00F3});
        pc = 16'h0002;
        issue(4'd8, 8'hF0, 16'h0);
        chk("R9 relative negative wrap", res_ea, 16'hFFF2);
        pc = 16'hFFF8;
        issue(4'd8, 8'h10, 16'h0);
        chk("R9 relative positive wrap", res_ea, 16'h0008);
        issue(4'd9, 8'hF0, 16'h0);
        chk("R10 indexed", res_ea, 16'h10F0);
        base_reg = 16'hFFF0;
        issue(4'd10, 8'h20, 16'h0);
        chk("R10 base wrap", res_ea, 16'h0010);
    endtask

    task automatic t_indirect;
        issue(4'd7, 8'h3C, 16'h0);
        chk("R7 fetch busy/rd", {busy, mem_rd_en, res_valid}, 3'b110);
        chk("R7 fetch addr", mem_rd_addr, 16'h003C);
        // R8: offer a direct request during the fetch cycle
        req_valid = 1'b1; req_mode = 4'd6; req_field = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 indirect result", {res_valid, res_is_addr, res_ea}, {2'b11, 16'h003C ^ 16'hA5C3});
        chk("R8 no new fetch", busy, 0);
        @(negedge clk);
        chk("R8 busy request ignored", {res_valid, busy, mem_rd_en}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_implied;
        t_imm_reg;
        t_auto;
        t_direct_rel_idx;
        t_indirect;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule